// File: doc/BRIEF.md
# Multicarrier Five-Level PWM Generator

This block produces the switching commands for a five-level inverter leg. It compares one scaled signed reference sample against four triangular carriers and registers one comparator bit per carrier. The reference sample is normally a sinusoid supplied by the surrounding control logic. The number of comparator bits that are high, minus two, is the commanded output level, from -2 to +2 in quarter-bus steps. Each comparator bit also drives one complementary gate pair through its own dead-time counter.

All four carriers are derived from one shared phase counter, so no carrier can drift against another. A 3-bit arrangement select picks how the carriers are placed. Three layouts stack the carriers in contiguous bands with different phase relations: all in phase, the upper pair against the lower pair, and alternating. A fourth layout keeps the bands but runs the two inner carriers at twice the rate. The other two layouts are a full-range layout with quarter-period shifts and a layout with half-amplitude overlaps. An unsigned modulation index scales the reference. Both the arrangement and the index are taken only at the end of a carrier period, so a change never produces a partial carrier.

Top module: `mcpwm_gen`

## Requirements
- R1: While reset is asserted: cmp_o is 0, level_o is -2, every gate_hi_o bit is 0 and every gate_lo_o bit is 1. The phase counter, the latched arrangement (code 0) and the latched index (0) are all cleared.
- R2: A phase counter of AW+1 bits steps once per clock, so one carrier period is 2A clocks, where A = 2^AW. mode_i and mi_i are captured only on the clock where the phase is 2A-1, and they act from phase 0 onwards.
- R3: On each clock, bit k of cmp_o is registered high when the scaled reference is strictly greater than carrier k; otherwise it is registered low. level_o equals the number of set cmp_o bits minus 2.
- R4: The scaled reference is floor(ref_i * mi / 256), where mi is the latched index and 256 stands for an index of 1.0.
- R5: Code 0 (in-phase bands): carrier k = T(ph) + (k-2)*A. Here T(p) = p mod 2A when that value is below A, and 2A minus it otherwise.
- R6: Code 1 (upper pair against lower pair): carriers 0 and 1 use T(ph+A), and carriers 2 and 3 use T(ph). Every carrier keeps the band offset (k-2)*A.
- R7: Code 2 (alternating bands): carriers 1 and 3 use T(ph+A), and carriers 0 and 2 use T(ph). Every carrier keeps the band offset (k-2)*A.
- R8: Code 3 (quarter-period shift): carrier k = 4*T(ph + k*A/2) - 2A. Every carrier spans the full reference range.
- R9: Code 4 (overlapping bands): carrier k = T(ph) - 5A/4 + k*A/2. Adjacent carriers overlap by half their height, and the group is centred on zero.
- R10: Code 5 (faster inner carriers): carriers 1 and 2 use T(2*ph), and carriers 0 and 3 use T(ph). Every carrier keeps the band offset (k-2)*A.
- R11: Codes 6 and 7 behave exactly like code 0.
- R12: After each change of cmp_o bit k, both gate_hi_o[k] and gate_lo_o[k] stay 0 for dt+1 clocks. Here dt is the dt_i value present on the clock that follows the change. After that, gate_hi_o[k] = cmp_o[k] and gate_lo_o[k] = !cmp_o[k].
- R13: When the comparator bits come from a banded arrangement (codes 0, 1, 2, 5, 6 or 7), cmp_o is a thermometer code: a set bit k implies that every bit below k is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Carrier arrangement select (codes as in R5 to R11) |
| mi_i | input | MIW | Modulation index, 256 = 1.0 |
| ref_i | input | AW+3 | Signed reference sample; full scale is ±2A |
| dt_i | input | DTW | Dead time in clocks, applied as dt+1 |
| cmp_o | output | 4 | Registered comparator bits, bit 0 = lowest carrier |
| level_o | output | 3 | Signed output level, -2 to +2 |
| gate_hi_o | output | 4 | Upper device command for each pair |
| gate_lo_o | output | 4 | Lower device command for each pair |

## Verification
Every arrangement code is driven with a sinusoidal reference at 22 carrier periods per reference period, at index values 1.0, 0.8 and 0.6. This separates the carrier shapes and phase relations, because the code-0, code-1 and code-2 layouts differ only in where each carrier crosses the reference. A slow ramp run at index 0.5 and at index 0 isolates the scaling from the carrier layout. Constant references at and beyond the full-scale limits check the strict comparison and the saturated levels. A run that changes the arrangement select every few clocks shows whether the select is taken only at the period boundary. The dead-time counter is checked at its shortest setting and at its longest setting.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

  localparam int NCAR = 4;

  typedef enum logic [2:0] {
    MODE_PD   = 3'd0,
    MODE_POD  = 3'd1,
    MODE_APOD = 3'd2,
    MODE_PS   = 3'd3,
    MODE_CO   = 3'd4,
    MODE_VF   = 3'd5
  } carrier_mode_e;

  function automatic carrier_mode_e norm_mode(input logic [2:0] raw);
    carrier_mode_e m;
    case (raw)
      3'd1:    m = MODE_POD;
      3'd2:    m = MODE_APOD;
      3'd3:    m = MODE_PS;
      3'd4:    m = MODE_CO;
      3'd5:    m = MODE_VF;
      default: m = MODE_PD;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase
  import mcpwm_pkg::*;
#(
  parameter int AW  = 4,
  parameter int MIW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic [MIW-1:0]   mi_i,
  output logic [AW:0]      ph_o,
  output carrier_mode_e    mode_o,
  output logic [MIW-1:0]   mi_o
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  logic [PW-1:0]   ph_q, ph_n;
  carrier_mode_e   mode_q, mode_n;
  logic [MIW-1:0]  mi_q, mi_n;
  logic            wrap;

  always_comb begin
    wrap   = (ph_q == PMAX);
    ph_n   = ph_q + 1'b1;
    mode_n = norm_mode(mode_i);
    mi_n   = mi_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      mode_q <= MODE_PD;
      mi_q   <= '0;
    end else begin
      ph_q <= ph_n;
      if (wrap) begin
        mode_q <= mode_n;
        mi_q   <= mi_n;
      end
    end
  end

  assign ph_o   = ph_q;
  assign mode_o = mode_q;
  assign mi_o   = mi_q;

  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PMAX) |=> (ph_q == '0));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PMAX) |=> (ph_q == $past(ph_q) + 1'b1));

  // R2
  mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PMAX) |=> ($stable(mode_q) && $stable(mi_q)));

endmodule

// File: rtl/mcpwm_carrier_bank.sv
module mcpwm_carrier_bank
  import mcpwm_pkg::*;
#(
  parameter int AW  = 4,
  parameter int CVW = AW + 4
) (
  input  logic [AW:0]           ph_i,
  input  carrier_mode_e         mode_i,
  output logic [NCAR*CVW-1:0]   car_o
);

  localparam int PW = AW + 1;
  localparam int A  = 1 << AW;
  localparam logic [PW-1:0]         HALF_TURN = PW'(A);
  localparam logic signed [CVW-1:0] FULL_TURN = CVW'(2 * A);

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    localparam logic signed [CVW-1:0] BAND_OFS = CVW'((k - 2) * A);
    localparam logic signed [CVW-1:0] OVL_OFS  = CVW'(k * (A / 2) - (5 * A) / 4);
    localparam logic [PW-1:0]         PS_SHIFT = PW'(k * (A / 2));
    localparam bit INNER    = (k == 1) || (k == 2);
    localparam bit LOW_HALF = (k < 2);
    localparam bit ODD      = (k % 2) == 1;

    logic [PW-1:0]          base, shift, pos;
    logic signed [CVW-1:0]  slope_v, val;

    always_comb begin
      if (mode_i == MODE_VF && INNER) base = {ph_i[PW-2:0], 1'b0};
      else                            base = ph_i;
      shift = '0;
      case (mode_i)
        MODE_POD:  if (LOW_HALF) shift = HALF_TURN;
        MODE_APOD: if (ODD)      shift = HALF_TURN;
        MODE_PS:   shift = PS_SHIFT;
        default:   shift = '0;
      endcase
      pos = base + shift;
      if (pos < HALF_TURN) slope_v = CVW'(pos);
      else                 slope_v = FULL_TURN - CVW'(pos);
      case (mode_i)
        MODE_PS: val = (slope_v <<< 2) - FULL_TURN;
        MODE_CO: val = slope_v + OVL_OFS;
        default: val = slope_v + BAND_OFS;
      endcase
    end

    assign car_o[k*CVW +: CVW] = val;
  end

endmodule

// File: rtl/mcpwm_ref_scale.sv
module mcpwm_ref_scale #(
  parameter int RW  = 7,
  parameter int MIW = 9,
  parameter int MIF = 8,
  parameter int PRW = RW + MIW + 1
) (
  input  logic signed [RW-1:0]  ref_i,
  input  logic [MIW-1:0]        mi_i,
  output logic signed [PRW-1:0] ref_o
);

  logic signed [PRW-1:0] ref_ext, mi_ext, prod;

  always_comb begin
    ref_ext = {{(PRW-RW){ref_i[RW-1]}}, ref_i};
    mi_ext  = {{(PRW-MIW){1'b0}}, mi_i};
    prod    = ref_ext * mi_ext;
    ref_o   = prod >>> MIF;
  end

endmodule

// File: rtl/mcpwm_deadtime.sv
module mcpwm_deadtime #(
  parameter int DTW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_i,
  input  logic [DTW-1:0] dt_i,
  output logic           hi_o,
  output logic           lo_o
);

  logic           prev_q, prev_n;
  logic [DTW-1:0] cnt_q, cnt_n;
  logic           chg, busy;

  always_comb begin
    chg    = (cmd_i != prev_q);
    prev_n = cmd_i;
    cnt_n  = cnt_q;
    if (chg)                cnt_n = dt_i;
    else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
    busy = chg || (cnt_q != '0);
    hi_o = cmd_i & ~busy;
    lo_o = ~cmd_i & ~busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_n;
      cnt_q  <= cnt_n;
    end
  end

  // R12
  hi_to_lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_o |=> !lo_o);

  // R12
  lo_to_hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_o |=> !hi_o);

endmodule

// File: rtl/mcpwm_gen.sv
module mcpwm_gen
  import mcpwm_pkg::*;
#(
  parameter int AW  = 4,
  parameter int MIW = 9,
  parameter int MIF = 8,
  parameter int DTW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode_i,
  input  logic [MIW-1:0]      mi_i,
  input  logic signed [AW+2:0] ref_i,
  input  logic [DTW-1:0]      dt_i,
  output logic [3:0]          cmp_o,
  output logic signed [2:0]   level_o,
  output logic [3:0]          gate_hi_o,
  output logic [3:0]          gate_lo_o
);

  localparam int RW  = AW + 3;
  localparam int CVW = AW + 4;
  localparam int PRW = RW + MIW + 1;

  logic [AW:0]                ph;
  carrier_mode_e              mode_l;
  logic [MIW-1:0]             mi_l;
  logic [NCAR*CVW-1:0]        car_flat;
  logic signed [PRW-1:0]      ref_s;
  logic [NCAR-1:0]            cmp_q, cmp_n;
  logic [2:0]                 ones;

  mcpwm_timebase #(.AW(AW), .MIW(MIW)) u_tb (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mi_i(mi_i),
    .ph_o(ph), .mode_o(mode_l), .mi_o(mi_l)
  );

  mcpwm_carrier_bank #(.AW(AW), .CVW(CVW)) u_car (
    .ph_i(ph), .mode_i(mode_l), .car_o(car_flat)
  );

  mcpwm_ref_scale #(.RW(RW), .MIW(MIW), .MIF(MIF), .PRW(PRW)) u_scale (
    .ref_i(ref_i), .mi_i(mi_l), .ref_o(ref_s)
  );

  for (genvar k = 0; k < NCAR; k++) begin : g_cmp
    logic signed [CVW-1:0] c;
    logic signed [PRW-1:0] c_ext;
    always_comb begin
      c        = car_flat[k*CVW +: CVW];
      c_ext    = {{(PRW-CVW){c[CVW-1]}}, c};
      cmp_n[k] = (ref_s > c_ext);
    end

    mcpwm_deadtime #(.DTW(DTW)) u_dt (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmp_q[k]), .dt_i(dt_i),
      .hi_o(gate_hi_o[k]), .lo_o(gate_lo_o[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_n;
  end

  always_comb begin
    ones    = 3'($countones(cmp_q));
    level_o = ones - 3'd2;
    cmp_o   = cmp_q;
  end

  // R13
  band_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_l != MODE_PS && mode_l != MODE_CO)) |-> $onehot({1'b0, cmp_q} + 5'd1));

endmodule

// File: tb/mcpwm_gen_tb.sv
module mcpwm_gen_tb;

  localparam int AW  = 4;
  localparam int A   = 1 << AW;
  localparam int MIW = 9;
  localparam int DTW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]         mode_i = '0;
  logic [MIW-1:0]     mi_i = '0;
  logic signed [6:0]  ref_i = '0;
  logic [DTW-1:0]     dt_i = '0;
  logic [3:0]         cmp_o;
  logic signed [2:0]  level_o;
  logic [3:0]         gate_hi_o, gate_lo_o;

  always #2.5 clk = ~clk;

  mcpwm_gen #(.AW(AW), .MIW(MIW), .MIF(8), .DTW(DTW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mi_i(mi_i), .ref_i(ref_i),
    .dt_i(dt_i), .cmp_o(cmp_o), .level_o(level_o),
    .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o)
  );

  typedef struct {
    int    cmp;
    int    lvl;
    int    hi;
    int    lo;
    bit    band;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_tag = "R5";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model
  function automatic int slope_f(input int p);
    int q;
    q = p % (2 * A);
    return (q < A) ? q : 2 * A - q;
  endfunction

  function automatic int car_f(input int md, input int k, input int ph);
    int m;
    m = (md > 5) ? 0 : md;
    case (m)
      1: return slope_f((k < 2) ? ph + A : ph) + (k - 2) * A;
      2: return slope_f((k % 2 == 1) ? ph + A : ph) + (k - 2) * A;
      3: return 4 * slope_f(ph + k * (A / 2)) - 2 * A;
      4: return slope_f(ph) - (5 * A) / 4 + k * (A / 2);
      5: return slope_f((k == 1 || k == 2) ? 2 * ph : ph) + (k - 2) * A;
      default: return slope_f(ph) + (k - 2) * A;
    endcase
  endfunction

  int m_ph, m_mode, m_mi, m_cmp;
  int m_prev[4];
  int m_cnt[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_mode = 0; m_mi = 0; m_cmp = 0;
      for (int k = 0; k < 4; k++) begin m_prev[k] = 0; m_cnt[k] = 0; end
    end else begin
      int rs, ncmp, hi, lo, md_old;
      exp_t e;
      rs = (int'(ref_i) * m_mi) >>> 8;
      ncmp = 0;
      for (int k = 0; k < 4; k++)
        if (rs > car_f(m_mode, k, m_ph)) ncmp |= (1 << k);
      for (int k = 0; k < 4; k++) begin
        int ob;
        ob = (m_cmp >> k) & 1;
        if (ob != m_prev[k]) m_cnt[k] = int'(dt_i);
        else if (m_cnt[k] != 0) m_cnt[k] = m_cnt[k] - 1;
        m_prev[k] = ob;
      end
      m_cmp = ncmp;
      hi = 0; lo = 0;
      for (int k = 0; k < 4; k++) begin
        int b;
        b = (m_cmp >> k) & 1;
        if (b == m_prev[k] && m_cnt[k] == 0) begin
          if (b == 1) hi |= (1 << k); else lo |= (1 << k);
        end
      end
      md_old = (m_mode > 5) ? 0 : m_mode;
      e.cmp = m_cmp; e.lvl = $countones(m_cmp) - 2; e.hi = hi; e.lo = lo;
      e.band = (md_old != 3 && md_old != 4);
      e.tag = cur_tag;
      sb.push_back(e);
      if (m_ph == 2 * A - 1) begin m_mode = int'(mode_i); m_mi = int'(mi_i); end
      m_ph = (m_ph + 1) % (2 * A);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(int'(cmp_o) == e.cmp, e.tag, "cmp (R3)", int'(cmp_o), e.cmp);
      chk(int'(level_o) == e.lvl, "R3", "level", int'(level_o), e.lvl);
      chk(int'(gate_hi_o) == e.hi && int'(gate_lo_o) == e.lo, "R12", "gates hi*16+lo",
          int'(gate_hi_o) * 16 + int'(gate_lo_o), e.hi * 16 + e.lo);
      if (e.band)
        chk($onehot({1'b0, cmp_o} + 5'd1), "R13", "thermometer cmp", int'(cmp_o), e.cmp);
    end
  end

  task automatic run(input int md, input int mi, input int dt, input int kind,
                     input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int v;
      @(negedge clk);
      cur_tag = tag;
      mode_i = 3'(md); mi_i = MIW'(mi); dt_i = DTW'(dt);
      case (kind)
        0: v = int'(2.0 * A * $sin(2.0 * 3.14159265 * i / (22.0 * 2 * A)));
        1: v = -40 + (i / 3) % 81;
        2: v = ((i / 37) % 2 == 0) ? 63 : -64;
        3: v = ((i / 37) % 2 == 0) ? 2 * A : -2 * A;
        default: v = 0;
      endcase
      ref_i = 7'(v);
    end
  endtask

  string mtag[8] = '{"R5", "R6", "R7", "R8", "R9", "R10", "R11", "R11"};

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmp_o == 4'd0, "R1", "cmp in reset", int'(cmp_o), 0);
    chk(level_o == -3'sd2, "R1", "level in reset", int'(level_o), -2);
    chk(gate_hi_o == 4'd0, "R1", "hi in reset", int'(gate_hi_o), 0);
    chk(gate_lo_o == 4'hF, "R1", "lo in reset", int'(gate_lo_o), 15);
    rst_n = 1'b1;
    for (int md = 0; md < 8; md++) begin
      run(md, 256, 3, 0, 704, mtag[md]);
      run(md, 205, 3, 0, 704, mtag[md]);
      run(md, 154, 3, 0, 704, mtag[md]);
    end
    // R2: arrangement select toggled mid-period
    for (int j = 0; j < 60; j++) run(j % 6, 256 - j, 2, 0, 7, "R2");
    // R4: scaling alone
    run(0, 128, 3, 1, 300, "R4");
    run(3, 0, 3, 1, 200, "R4");
    // R3: strict comparison at and beyond full scale
    run(0, 256, 1, 3, 300, "R3");
    run(4, 256, 1, 2, 300, "R3");
    // R12: shortest and longest dead time
    run(0, 256, 0, 1, 400, "R12");
    run(5, 256, 15, 0, 704, "R12");
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule